// File: doc/BRIEF.md
# Double-Buffered Multi-Mode Serial Transmitter

This block is the transmit half of a serial port. Software writes a byte into a one-entry holding register. Whenever the shift register is free, the byte moves into it on the next bit-rate tick. The holding register's empty flag sets at that moment, so the following byte can be written while the current one is still going out on the line. An interrupt request is raised while the holding register is empty and the interrupt is enabled.

Four frame formats are selected by a control register:
- an asynchronous format with optional even or odd parity;
- a multiprocessor format that sends an address/data marker bit in the parity slot;
- a clocked synchronous format that sends bare data bytes back to back and drives a shift clock, with optional start and stop framing;
- a plain 8-bit framed format.

One serial bit is sent per bit-rate tick. Data goes out least-significant bit first.

Top module: `sertx_top`

## Requirements
- R1: The empty flag sets at the same clock edge that moves the held byte into the shift register. At that edge the first bit of the new frame (the start bit in framed formats) appears on `ser_out`. The transfer happens only on a clock edge where `bit_tick` is 1.
- R2: Only a data write (`wr_en`=1, `wr_sel`=0) clears the empty flag. A control write (`wr_sel`=1) leaves the flag unchanged.
- R3: `tx_irq` is 1 exactly when the empty flag is 1 and the interrupt-enable control bit (bit 6) is 1.
- R4: A framed byte is sent as a 0 start bit, then D0 through D7, then a 1 stop bit. Each bit lasts one tick period, and the line rests at 1 between frames. Mode 0 (control bits [1:0] = 0) with parity disabled gives a 10-bit frame.
- R5: In mode 0 with control bit 2 set, a parity bit follows D7 and comes before the stop bit. With control bit 3 at 0 the parity is even, meaning the data plus the parity bit hold an even number of ones. With bit 3 at 1 the parity is odd.
- R6: In mode 1, the bit after D7 carries the value of control bit 4, followed by the stop bit.
- R7: In mode 2 with control bit 5 at 0, each byte is sent as its 8 data bits only, with no start, stop or parity bit. A byte written while the previous one is shifting follows it with no idle bit period in between.
- R8: In mode 2 with control bit 5 at 1, and in mode 3, each byte gets a start bit and a stop bit (10 bits). No parity bit is sent, even when control bit 2 is set.
- R9: In mode 2, `ser_clk` goes low for exactly one clock cycle at the start of each transmitted bit and is 1 otherwise. In all other modes, and while idle, `ser_clk` stays at 1.
- R10: A byte written while a frame is in progress waits in the holding register, with the empty flag at 0, until the current frame's last bit ends. It then starts immediately, with no idle bit period.
- R11: After reset, `ser_out`=1, `ser_clk`=1, the empty flag is 1, `tx_irq`=0 and every control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the data register, 1 the control register |
| wr_data | input | 8 | Write data; control layout [1:0] mode, [2] parity enable, [3] odd parity, [4] address bit, [5] sync framing enable, [6] interrupt enable |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| ser_out | output | 1 | Serial data line |
| ser_clk | output | 1 | Synchronous shift clock (active-low pulse per bit) |
| tx_empty | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench first aims at when the empty flag sets. A design that set it at frame end would hold the flag at 0 through the whole first frame. It would also leave a gap between two queued frames instead of sending them back to back. The bench sends a byte whose parity bit is 0 in mode 3 and in framed mode 2. A design that leaked parity into those modes would put a 0 where the stop bit belongs. In bare synchronous mode it counts the clock pulses and checks that they fall on consecutive bit periods, which catches an idle slot between bytes or any start or stop bits. It also confirms that a control write leaves the empty flag set and that the odd and even parity selections produce opposite bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_MPROC = 2'd1,
        MODE_SYNC  = 2'd2,
        MODE_BYTE  = 2'd3
    } tx_mode_e;

    typedef struct packed {
        logic     irq_en;
        logic     sync_framed;
        logic     addr_bit;
        logic     par_odd;
        logic     par_en;
        tx_mode_e mode;
    } tx_ctrl_t;

    localparam int CTRL_W = $bits(tx_ctrl_t);

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
        logic               sync_clk;
    } tx_frame_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  tx_ctrl_t          ctrl,
    output tx_frame_t         frame
);
    logic framed;
    logic extra_en;
    logic extra_bit;

    always_comb begin
        framed    = !(ctrl.mode == MODE_SYNC && !ctrl.sync_framed);
        extra_en  = (ctrl.mode == MODE_ASYNC && ctrl.par_en) || (ctrl.mode == MODE_MPROC);
        extra_bit = (ctrl.mode == MODE_MPROC) ? ctrl.addr_bit : parity_of(data, ctrl.par_odd);
        frame.sync_clk = (ctrl.mode == MODE_SYNC);
        if (!framed) begin
            frame.bits = {{(FRAME_W-DATA_W){1'b1}}, data};
            frame.len  = CNT_W'(DATA_W);
        end else if (extra_en) begin
            frame.bits = {1'b1, extra_bit, data, 1'b0};
            frame.len  = CNT_W'(DATA_W + 3);
        end else begin
            frame.bits = {1'b1, 1'b1, data, 1'b0};
            frame.len  = CNT_W'(DATA_W + 2);
        end
    end
endmodule

// File: rtl/sertx_holdreg.sv
module sertx_holdreg
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              shifter_free,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty,
    output logic              load
);
    assign load = tick && !empty && shifter_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty     <= 1'b1;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            empty     <= 1'b0;
        end else if (load) begin
            empty     <= 1'b1;
        end
    end

    assert_empty_set_on_load_R1: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> empty);

    assert_empty_kept_without_write_R2: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en) |=> empty);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  tx_frame_t frame_in,
    output logic      sout,
    output logic      sclk,
    output logic      free
);
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   left;
    logic               busy;
    logic               sync_q;
    logic               low_q;

    assign free = !busy || (left == CNT_W'(1));
    assign sout = sr[0];
    assign sclk = !low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '1;
            left   <= '0;
            busy   <= 1'b0;
            sync_q <= 1'b0;
            low_q  <= 1'b0;
        end else begin
            low_q <= 1'b0;
            if (load) begin
                sr     <= frame_in.bits;
                left   <= frame_in.len;
                busy   <= 1'b1;
                sync_q <= frame_in.sync_clk;
                low_q  <= frame_in.sync_clk;
            end else if (tick && busy) begin
                if (left == CNT_W'(1)) begin
                    sr   <= '1;
                    left <= '0;
                    busy <= 1'b0;
                end else begin
                    sr    <= {1'b1, sr[FRAME_W-1:1]};
                    left  <= left - CNT_W'(1);
                    low_q <= sync_q;
                end
            end
        end
    end

    assert_load_when_free_R10: assert property (@(posedge clk) disable iff (rst)
        load |-> free);

    assert_idle_lines_high_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> (sout && sclk));

    assert_bit_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0 && left <= CNT_W'(FRAME_W)));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_tick,
    output logic              ser_out,
    output logic              ser_clk,
    output logic              tx_empty,
    output logic              tx_irq
);
    tx_ctrl_t          ctrl;
    tx_frame_t         frame;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              free;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_en && wr_sel)
            ctrl <= tx_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    sertx_holdreg u_hold (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en && !wr_sel),
        .wr_data      (wr_data),
        .tick         (bit_tick),
        .shifter_free (free),
        .hold_data    (hold_data),
        .empty        (tx_empty),
        .load         (load)
    );

    sertx_framer u_frm (
        .data  (hold_data),
        .ctrl  (ctrl),
        .frame (frame)
    );

    sertx_shifter u_sh (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .load     (load),
        .frame_in (frame),
        .sout     (ser_out),
        .sclk     (ser_clk),
        .free     (free)
    );

    assign tx_irq = tx_empty && ctrl.irq_en;
endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       ser_out, ser_clk, tx_empty, tx_irq;

    int n_chk = 0;
    int n_fail = 0;
    int slot = 0;
    bit q_all[$];
    bit q_clk[$];

    always #4 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bit_tick(bit_tick), .ser_out(ser_out), .ser_clk(ser_clk),
        .tx_empty(tx_empty), .tx_irq(tx_irq)
    );

    // tick every 4th cycle; record line state just after each tick edge
    always @(negedge clk) begin
        if (bit_tick) begin
            q_all.push_back(ser_out);
            q_clk.push_back(ser_clk);
        end
        slot++;
        bit_tick = (slot % 4 == 0);
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4 * 16) @(negedge clk);
    endtask

    function automatic int first_zero();
        for (int k = 0; k < q_all.size(); k++)
            if (q_all[k] == 1'b0) return k;
        return -1;
    endfunction

    task automatic run_framed(input string r, input logic [7:0] c, input logic [7:0] d,
                              input logic [11:0] exp);
        logic [11:0] act;
        int i, lows;
        wr(1'b1, c);
        settle();
        q_all.delete(); q_clk.delete();
        wr(1'b0, d);
        repeat (4 * 15) @(negedge clk);
        i = first_zero();
        act = '1;
        for (int k = 0; k < 12; k++)
            if (i >= 0 && i + k < q_all.size()) act[k] = q_all[i + k];
        chk(r, act, exp);
        lows = 0;
        foreach (q_clk[k]) if (q_clk[k] == 1'b0) lows++;
        chk({r, " R9 no shift clock"}, lows, 0);
    endtask

    task automatic test_reset();
        chk("R11 ser_out", ser_out, 1);
        chk("R11 ser_clk", ser_clk, 1);
        chk("R11 empty", tx_empty, 1);
        chk("R11 irq", tx_irq, 0);
    endtask

    task automatic test_async();
        run_framed("R4 8N1", 8'h00, 8'hA5, {3'b111, 8'hA5, 1'b0});
        run_framed("R5 even", 8'h04, 8'h07, {2'b11, ^8'h07, 8'h07, 1'b0});
        run_framed("R5 odd", 8'h0C, 8'h07, {2'b11, ~^8'h07, 8'h07, 1'b0});
    endtask

    task automatic test_mproc();
        run_framed("R6 addr1", 8'h11, 8'h80, {2'b11, 1'b1, 8'h80, 1'b0});
        run_framed("R6 addr0", 8'h01, 8'h81, {2'b11, 1'b0, 8'h81, 1'b0});
    endtask

    task automatic test_no_parity_modes();
        // 0x03 has even parity bit 0: a leaked parity bit would replace the stop bit
        run_framed("R8 mode3", 8'h07, 8'h03, {3'b111, 8'h03, 1'b0});
    endtask

    task automatic test_sync_framed();
        logic [11:0] act;
        int i, lows;
        wr(1'b1, 8'h26);
        settle();
        q_all.delete(); q_clk.delete();
        wr(1'b0, 8'h03);
        repeat (4 * 15) @(negedge clk);
        i = first_zero();
        act = '1;
        for (int k = 0; k < 12; k++)
            if (i >= 0 && i + k < q_all.size()) act[k] = q_all[i + k];
        chk("R8 mode2 framed", act, {3'b111, 8'h03, 1'b0});
        lows = 0;
        foreach (q_clk[k]) if (q_clk[k] == 1'b0) lows++;
        chk("R9 mode2 framed clock pulses", lows, 10);
    endtask

    task automatic test_sync_bare();
        logic [15:0] got;
        int n, first, last, guard;
        wr(1'b1, 8'h02);
        settle();
        q_all.delete(); q_clk.delete();
        wr(1'b0, 8'h3C);
        guard = 0;
        while (!tx_empty && guard < 40) begin @(negedge clk); guard++; end
        wr(1'b0, 8'hC3);
        repeat (4 * 22) @(negedge clk);
        got = '0; n = 0; first = -1; last = -1;
        foreach (q_clk[k]) begin
            if (q_clk[k] == 1'b0) begin
                if (n < 16) got[n] = q_all[k];
                n++;
                if (first < 0) first = k;
                last = k;
            end
        end
        chk("R7 bare sync data", got, 16'hC33C);
        chk("R9 bare sync pulse count", n, 16);
        chk("R7 no gap between bytes", last - first, 15);
        chk("R9 clock idle high", ser_clk, 1);
    endtask

    task automatic test_flag_timing();
        logic [19:0] act;
        logic prev;
        int i, guard;
        wr(1'b1, 8'h40);
        settle();
        chk("R3 irq while empty", tx_irq, 1);
        q_all.delete(); q_clk.delete();
        wr(1'b0, 8'h5A);
        chk("R2 data write clears empty", tx_empty, 0);
        chk("R3 irq drops", tx_irq, 0);
        prev = ser_out;
        guard = 0;
        while (!tx_empty && guard < 12) begin
            prev = ser_out;
            @(negedge clk);
            guard++;
        end
        chk("R1 empty sets with start bit", {prev, ser_out}, 2'b10);
        chk("R3 irq on transfer", tx_irq, 1);
        wr(1'b0, 8'h96);
        repeat (4 * 5) @(negedge clk);
        chk("R10 held while busy", tx_empty, 0);
        guard = 0;
        while (!tx_empty && guard < 60) begin @(negedge clk); guard++; end
        repeat (4 * 14) @(negedge clk);
        i = first_zero();
        act = '1;
        for (int k = 0; k < 20; k++)
            if (i >= 0 && i + k < q_all.size()) act[k] = q_all[i + k];
        chk("R10 back-to-back frames", act, {1'b1, 8'h96, 1'b0, 1'b1, 8'h5A, 1'b0});
        wr(1'b1, 8'h00);
        chk("R2 control write keeps empty", tx_empty, 1);
        chk("R3 irq disabled", tx_irq, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_async();
        test_mproc();
        test_no_parity_modes();
        test_sync_framed();
        test_sync_bare();
        test_flag_timing();
        summary();
    end
endmodule